// File: doc/BRIEF.md
# Dual Alarm Compare Unit

This block watches a running BCD calendar supplied by a separate counter and compares it against two alarm time registers. Each alarm holds a seconds, minutes, hours, day, month and year value, and an alarm is declared only when all six equal the current time. No field can be marked as "don't care". A hit on either alarm sets a sticky status flag, which software clears by writing a one to it. Each one-second update also sets a sticky timer-event flag.

The flags drive three outputs. The interrupt line combines each flag with its own enable bit. A separate wake-enable bit sends the first alarm to a wakeup line. The second alarm can drop a power-enable output to switch off an external power controller. The comparison is made only on the cycle that carries the once-per-second update strobe. The block reads the time inputs and stored alarm values in that cycle.

Top module: `dual_alarm_unit`

## Requirements
- R1: Alarm A fields are 8-bit registers at byte offsets 0x20, 0x24, 0x28, 0x2C, 0x30, 0x34 holding seconds, minutes, hours, day, month, year. Alarm B fields use the same order at 0x80 to 0x94. Each reads back the low 8 bits last written and resets to 0.
- R2: An alarm flag is set only in a cycle where `tick_i` is high. An equal time with no strobe never sets a flag.
- R3: On a strobe, alarm A sets status bit 6 and alarm B sets status bit 7, but only when all six fields equal the `now_i` bytes. `now_i` holds seconds in bits 7:0 up to year in bits 47:40. A difference in any one field prevents the set. The status register is at 0x44.
- R4: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged. If a set and a clear land in the same cycle, the set wins.
- R5: Every strobe sets status bit 2, the timer event, which is cleared in the same way as R4.
- R6: The enable register at 0x48 uses bit 2 for the timer, bit 3 for alarm A and bit 4 for alarm B. Other bits read as 0. `irq_o` is the OR over the three sources of flag AND enable.
- R7: Bit 1 of the register at 0x7C is the wake enable. `wake_o` is high exactly while this bit and the alarm A flag are both set, whatever the interrupt enables hold.
- R8: Bit 16 of the register at 0x98 is the power-off arm. `pwr_en_o` is high except while this bit and the alarm B flag are both set.
- R9: A strobe compares against the alarm value held before a write made in the same cycle. The new value takes part from the next strobe on.
- R10: After reset, all registers read 0, `irq_o` and `wake_o` are low, and `pwr_en_o` is high. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle once-per-second calendar update strobe |
| now_i | input | 48 | Current BCD time, seconds in bits 7:0 through year in bits 47:40 |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 8 | Register byte offset |
| bus_wdata_i | input | 32 | Register write data |
| bus_rdata_o | output | 32 | Register read data, combinational from the address |
| irq_o | output | 1 | Combined interrupt |
| wake_o | output | 1 | Wakeup request from alarm A |
| pwr_en_o | output | 1 | Power enable to external controller, low means off |

## Verification
The hardest case to reach is a strobe that coincides with a bus write, either a write-one clear of the flag being set or a rewrite of the field being compared. In normal use these two events are independent. The bench has a task that raises `tick_i` and the bus write in the same cycle. This shows that the set wins over the clear and that the old alarm value is the one compared. A further sweep brings every combination of the three flags and three enables to the interrupt output. It builds each flag pattern by first setting all flags with one strobe and then clearing the complement.

// File: rtl/dual_alarm_pkg.sv
package dual_alarm_pkg;
  localparam int FLD_W   = 8;
  localparam int NUM_FLD = 6;
  localparam int NUM_ALM = 2;
  localparam int ADDR_W  = 8;
  localparam int DATA_W  = 32;

  localparam logic [ADDR_W-1:0] ALM_A_BASE = 8'h20;
  localparam logic [ADDR_W-1:0] ALM_B_BASE = 8'h80;
  localparam logic [ADDR_W-1:0] OFS_STAT   = 8'h44;
  localparam logic [ADDR_W-1:0] OFS_IEN    = 8'h48;
  localparam logic [ADDR_W-1:0] OFS_WAKE   = 8'h7C;
  localparam logic [ADDR_W-1:0] OFS_PWR    = 8'h98;

  localparam int ST_TMR = 2;
  localparam int ST_AA  = 6;
  localparam int ST_AB  = 7;
  localparam int IE_TMR = 2;
  localparam int IE_AB  = 4;
  localparam int WK_AA  = 1;
  localparam int PW_ARM = 16;

  function automatic logic [ADDR_W-1:0] alm_base(input int k);
    return (k == 0) ? ALM_A_BASE : ALM_B_BASE;
  endfunction
endpackage

// File: rtl/dual_alarm_bank.sv
module dual_alarm_bank #(
  parameter int              FW   = 8,
  parameter int              NF   = 6,
  parameter int              AW   = 8,
  parameter logic [AW-1:0]   BASE = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    addr,
  input  logic [FW-1:0]    wdata,
  input  logic [NF*FW-1:0] now_i,
  output logic [NF*FW-1:0] fields_o,
  output logic             hit_o
);
  localparam int STRIDE = 4;

  logic [NF-1:0] ld;
  logic [NF-1:0] eq;

  for (genvar i = 0; i < NF; i++) begin : g_fld
    localparam logic [AW-1:0] FADDR = BASE + AW'(STRIDE * i);
    logic [FW-1:0] fld_q;
    logic [FW-1:0] fld_d;

    always_comb begin
      ld[i] = wr_en && (addr == FADDR);
      fld_d = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      fld_q <= '0;
      else if (ld[i])  fld_q <= fld_d;
    end

    assign eq[i]                 = (fld_q == now_i[i*FW +: FW]);
    assign fields_o[i*FW +: FW]  = fld_q;
  end

  assign hit_o = &eq;

  AST_FIELDS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(fields_o)); // R1
endmodule

// File: rtl/dual_alarm_status.sv
module dual_alarm_status #(
  parameter int NA = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic [NA-1:0] hit_i,
  input  logic          clr_we,
  input  logic          clr_tmr,
  input  logic [NA-1:0] clr_alm,
  output logic          tmr_f_o,
  output logic [NA-1:0] alm_f_o
);
  logic          tmr_q, tmr_d;
  logic [NA-1:0] alm_q, alm_d;

  always_comb begin
    tmr_d = tick_i | (tmr_q & ~(clr_we & clr_tmr));
    for (int k = 0; k < NA; k++)
      alm_d[k] = (tick_i & hit_i[k]) | (alm_q[k] & ~(clr_we & clr_alm[k]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_q <= 1'b0;
      alm_q <= '0;
    end else begin
      tmr_q <= tmr_d;
      alm_q <= alm_d;
    end
  end

  assign tmr_f_o = tmr_q;
  assign alm_f_o = alm_q;

  AST_TMR_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    tick_i |=> tmr_f_o); // R5

  for (genvar k = 0; k < NA; k++) begin : g_chk
    AST_MATCH_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_i && hit_i[k]) |=> alm_f_o[k]); // R3
    AST_SET_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(alm_f_o[k]) |-> $past(tick_i)); // R2
    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_we && clr_alm[k] && !tick_i) |=> !alm_f_o[k]); // R4
  end
endmodule

// File: rtl/dual_alarm_unit.sv
module dual_alarm_unit
  import dual_alarm_pkg::*;
#(
  parameter int FW = FLD_W,
  parameter int NF = NUM_FLD,
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic [NF*FW-1:0] now_i,
  input  logic             bus_we_i,
  input  logic [AW-1:0]    bus_addr_i,
  input  logic [DW-1:0]    bus_wdata_i,
  output logic [DW-1:0]    bus_rdata_o,
  output logic             irq_o,
  output logic             wake_o,
  output logic             pwr_en_o
);
  localparam int NA   = NUM_ALM;
  localparam int IEN_W = IE_AB - IE_TMR + 1;

  logic [NA-1:0][NF*FW-1:0] bank_fields;
  logic [NA-1:0]            bank_hit;
  logic                     tmr_f;
  logic [NA-1:0]            alm_f;

  logic [IEN_W-1:0] ien_q, ien_d;
  logic             wake_q, wake_d;
  logic             pwr_q, pwr_d;
  logic             stat_we;

  for (genvar k = 0; k < NA; k++) begin : g_bank
    dual_alarm_bank #(.FW(FW), .NF(NF), .AW(AW), .BASE(alm_base(k))) bank_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (bus_we_i),
      .addr     (bus_addr_i),
      .wdata    (bus_wdata_i[FW-1:0]),
      .now_i    (now_i),
      .fields_o (bank_fields[k]),
      .hit_o    (bank_hit[k])
    );
  end

  assign stat_we = bus_we_i && (bus_addr_i == OFS_STAT);

  dual_alarm_status #(.NA(NA)) stat_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_i  (tick_i),
    .hit_i   (bank_hit),
    .clr_we  (stat_we),
    .clr_tmr (bus_wdata_i[ST_TMR]),
    .clr_alm ({bus_wdata_i[ST_AB], bus_wdata_i[ST_AA]}),
    .tmr_f_o (tmr_f),
    .alm_f_o (alm_f)
  );

  // control registers: next state
  always_comb begin
    ien_d  = ien_q;
    wake_d = wake_q;
    pwr_d  = pwr_q;
    if (bus_we_i) begin
      if (bus_addr_i == OFS_IEN)  ien_d  = bus_wdata_i[IE_AB:IE_TMR];
      if (bus_addr_i == OFS_WAKE) wake_d = bus_wdata_i[WK_AA];
      if (bus_addr_i == OFS_PWR)  pwr_d  = bus_wdata_i[PW_ARM];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien_q  <= '0;
      wake_q <= 1'b0;
      pwr_q  <= 1'b0;
    end else begin
      ien_q  <= ien_d;
      wake_q <= wake_d;
      pwr_q  <= pwr_d;
    end
  end

  // read mux
  always_comb begin
    bus_rdata_o = '0;
    case (bus_addr_i)
      OFS_STAT: begin
        bus_rdata_o[ST_TMR] = tmr_f;
        bus_rdata_o[ST_AA]  = alm_f[0];
        bus_rdata_o[ST_AB]  = alm_f[1];
      end
      OFS_IEN:  bus_rdata_o[IE_AB:IE_TMR] = ien_q;
      OFS_WAKE: bus_rdata_o[WK_AA]        = wake_q;
      OFS_PWR:  bus_rdata_o[PW_ARM]       = pwr_q;
      default:  ;
    endcase
    for (int k = 0; k < NA; k++)
      for (int i = 0; i < NF; i++)
        if (bus_addr_i == alm_base(k) + AW'(4 * i))
          bus_rdata_o = DW'(bank_fields[k][i*FW +: FW]);
  end

  assign irq_o    = (tmr_f & ien_q[0]) | (alm_f[0] & ien_q[1]) | (alm_f[1] & ien_q[2]);
  assign wake_o   = wake_q & alm_f[0];
  assign pwr_en_o = ~(pwr_q & alm_f[1]);

  logic unused_wdata;
  assign unused_wdata = ^{bus_wdata_i[DW-1:PW_ARM+1], bus_wdata_i[PW_ARM-1:ST_AB+1],
                          bus_wdata_i[ST_AA-1:IE_AB+1], bus_wdata_i[FW-1:0]};

  AST_IRQ_FOLLOWS_AA: assert property (@(posedge clk) disable iff (!rst_n)
    (alm_f[0] && ien_q[1]) |-> irq_o); // R6
  AST_PWR_HIGH_UNARMED: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_q |-> pwr_en_o); // R8
  AST_NO_WAKE_UNARMED: assert property (@(posedge clk) disable iff (!rst_n)
    !wake_q |-> !wake_o); // R7
endmodule

// File: tb/dual_alarm_unit_tb.sv
`timescale 1ns/1ps
module dual_alarm_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic [47:0] now = '0;
  logic        we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, wake, pwr_en;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dual_alarm_unit dut_i (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .now_i(now),
    .bus_we_i(we), .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .irq_o(irq), .wake_o(wake), .pwr_en_o(pwr_en)
  );

  localparam logic [7:0] T_SEC = 8'h58, T_MIN = 8'h59, T_HR = 8'h23,
                         T_DAY = 8'h31, T_MON = 8'h12, T_YR = 8'h25;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic pulse;
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic pulse_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); tick = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk); tick = 1'b0; we = 1'b0;
  endtask

  function automatic logic [7:0] tfield(input int i);
    case (i)
      0: return T_SEC; 1: return T_MIN; 2: return T_HR;
      3: return T_DAY; 4: return T_MON; default: return T_YR;
    endcase
  endfunction

  function automatic logic [7:0] base(input int k);
    return (k == 0) ? 8'h20 : 8'h80;
  endfunction

  task automatic prog_match(input int k, input int skip);
    for (int i = 0; i < 6; i++)
      wr(base(k) + 8'(4 * i), {24'h0, (i == skip) ? (tfield(i) ^ 8'h01) : tfield(i)});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    now = {T_YR, T_MON, T_DAY, T_HR, T_MIN, T_SEC};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R10 reset state
    chk("R10 irq reset", {31'b0, irq}, 32'd0);
    chk("R10 wake reset", {31'b0, wake}, 32'd0);
    chk("R10 pwr_en reset", {31'b0, pwr_en}, 32'd1);
    rd(8'h44, v); chk("R10 status reset", v, 32'h0);
    rd(8'h48, v); chk("R10 ien reset", v, 32'h0);
    rd(8'h98, v); chk("R10 pwr reg reset", v, 32'h0);
    for (int i = 0; i < 6; i++) begin
      rd(8'h20 + 8'(4 * i), v); chk("R10 alarm A field reset", v, 32'h0);
    end

    // R1 readback of all fields
    for (int i = 0; i < 6; i++) begin
      wr(8'h20 + 8'(4 * i), 32'hFFFF_FF00 | 32'(8'h11 * (i + 1)));
      wr(8'h80 + 8'(4 * i), 32'(8'h50 + i));
    end
    for (int i = 0; i < 6; i++) begin
      rd(8'h20 + 8'(4 * i), v); chk("R1 alarm A readback", v, 32'(8'h11 * (i + 1)));
      rd(8'h80 + 8'(4 * i), v); chk("R1 alarm B readback", v, 32'(8'h50 + i));
    end
    wr(8'h48, 32'hFFFF_FFFF); rd(8'h48, v); chk("R6 ien mask", v, 32'h1C);
    wr(8'h48, 32'h0);
    rd(8'h00, v); chk("R10 unmapped 0x00", v, 32'h0);
    rd(8'h3C, v); chk("R10 unmapped 0x3C", v, 32'h0);

    // R3 single-field mismatch sweep on both alarms
    for (int k = 0; k < 2; k++) begin
      prog_match(1 - k, 5);
      for (int f = 0; f <= 6; f++) begin
        prog_match(k, f);
        wr(8'h44, 32'hC4);
        pulse;
        rd(8'h44, v);
        chk("R3 match sweep", v, 32'h04 | ((f == 6) ? (32'h1 << (6 + k)) : 32'h0));
      end
    end

    // R2 equality without strobe
    prog_match(0, 6); prog_match(1, 6);
    wr(8'h44, 32'hC4);
    repeat (5) @(negedge clk);
    rd(8'h44, v); chk("R2 no strobe no flag", v, 32'h0);
    pulse; rd(8'h44, v); chk("R5 R3 strobe sets all", v, 32'hC4);

    // R6 exhaustive flag x enable sweep
    for (int m = 0; m < 8; m++) begin
      wr(8'h44, 32'hC4);
      pulse;
      wr(8'h44, (m[0] ? 32'h0 : 32'h04) | (m[1] ? 32'h0 : 32'h40) | (m[2] ? 32'h0 : 32'h80));
      rd(8'h44, v);
      chk("R4 partial clear", v, (m[0] ? 32'h04 : 0) | (m[1] ? 32'h40 : 0) | (m[2] ? 32'h80 : 0));
      for (int e = 0; e < 8; e++) begin
        wr(8'h48, 32'(e) << 2);
        #1 chk("R6 irq combine", {31'b0, irq}, {31'b0, |(m[2:0] & e[2:0])});
      end
    end
    wr(8'h48, 32'h0);

    // R7 wake
    for (int w = 0; w < 2; w++)
      for (int a = 0; a < 2; a++) begin
        wr(8'h44, 32'hC4);
        if (a == 1) pulse;
        wr(8'h7C, 32'(w) << 1);
        #1 chk("R7 wake", {31'b0, wake}, 32'(w & a));
      end
    wr(8'h7C, 32'h0);

    // R8 power enable
    for (int p = 0; p < 2; p++)
      for (int a = 0; a < 2; a++) begin
        wr(8'h44, 32'hC4);
        if (a == 1) pulse;
        wr(8'h98, 32'(p) << 16);
        #1 chk("R8 pwr_en", {31'b0, pwr_en}, 32'(!(p == 1 && a == 1)));
      end
    wr(8'h98, 32'h0);

    // R4 set beats same-cycle clear; zero write keeps
    wr(8'h44, 32'hC4);
    pulse_wr(8'h44, 32'hC4);
    rd(8'h44, v); chk("R4 set wins over clear", v, 32'hC4);
    wr(8'h44, 32'h40); rd(8'h44, v); chk("R4 clear one bit", v, 32'h84);
    wr(8'h44, 32'h00); rd(8'h44, v); chk("R4 zero write keeps", v, 32'h84);
    wr(8'h44, 32'h04); rd(8'h44, v); chk("R5 timer clear", v, 32'h80);

    // R9 old value compared on same-cycle write
    wr(8'h20, 32'h00);
    wr(8'h44, 32'hC4);
    pulse_wr(8'h20, {24'h0, T_SEC});
    rd(8'h44, v); chk("R9 old value compared", v, 32'h84);
    rd(8'h20, v); chk("R9 write landed", v, {24'h0, T_SEC});
    wr(8'h44, 32'hC4);
    pulse;
    rd(8'h44, v); chk("R9 new value next strobe", v, 32'hC4);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule